// File: doc/BRIEF.md
# Field-Recursive Luminance Flicker Filter

This pixel-rate datapath cuts interlace flicker. It blends each 8-bit luminance sample with the luminance of the same pixel one field earlier. The field-delayed sample arrives as a stream on the composite-path input, and the current sample arrives on the alternate pixel input. The blend happens only when the two samples differ by more than a selectable threshold. Otherwise the current sample passes through unchanged. The blend weights are either half and half, or three quarters current to one quarter delayed.

A key input has two meanings. In filter mode, key HIGH keys the composite-path data over the pixel stream, and key LOW asks for the filtered luminance. With filter mode off, the key is a plain 2:1 select between the two streams. A one-byte control register sets the filter mode, the ratio and the threshold. A master enable bit in the same register gates all three; when the enable is clear, the block is a plain keyer. Output data, key and valid are registered and advance together with one clock of latency.

Top module: `luma_flicker_filter`

## Requirements
- R1: A synchronous active-high reset clears out_valid, out_key, out_luma and cfg_rdata to zero.
- R2: out_valid and out_key equal in_valid and in_key of the previous clock. Every output has exactly one clock of latency.
- R3: When filtering is not in effect, out_luma equals in_cvbs if in_key was 1, and in_pd if in_key was 0.
- R4: When filtering is in effect and in_key is 1, out_luma equals in_cvbs.
- R5: When filtering is in effect and in_key is 0, and |in_pd − in_cvbs| does not exceed the active threshold, out_luma equals in_pd.
- R6: When the blend fires with ratio bit (cfg bit 2) equal to 0, out_luma = (in_pd + in_cvbs + 1) >> 1.
- R7: When the blend fires with ratio bit equal to 1, out_luma = (3·in_pd + in_cvbs + 2) >> 2.
- R8: Threshold bit (cfg bit 3) = 0 selects the high threshold (default 32), and 1 selects the low threshold (default 8). The blend fires only when the difference is strictly greater than the threshold.
- R9: Filtering is in effect only when both the master enable (cfg bit 0) and the filter-mode bit (cfg bit 1) are 1. With the enable clear, bits 1 to 3 are ignored.
- R10: A write with cfg_we loads all 8 bits of cfg_wdata. From the next clock on, cfg_rdata returns exactly the written byte and holds it until the next write.
- R11: A blended output always lies between the smaller and larger of the two input samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data (bit0 enable, bit1 filter mode, bit2 ratio, bit3 low threshold) |
| cfg_rdata | output | 8 | Control register readback |
| in_valid | input | 1 | Input sample strobe |
| in_key | input | 1 | Key input |
| in_cvbs | input | 8 | Composite-path data, or field-delayed luminance in filter mode |
| in_pd | input | 8 | Alternate pixel data, or current luminance in filter mode |
| out_valid | output | 1 | Registered sample strobe |
| out_key | output | 1 | Registered key |
| out_luma | output | 8 | Registered output luminance |

## Verification
The cases that are hard to reach from the ports are differences that sit exactly on a threshold (32 versus 33, and 8 versus 9), in either subtraction direction. Uniform random samples almost never land there. Directed pairs place the difference on and just past each threshold under both ratio settings. The directed cases also drive the full-scale extremes of 0 and 255. Random runs reconfigure the control byte every few dozen samples. Many of those control bytes have the enable clear while the other bits are set, which shows that the gated bits are ignored.

// File: rtl/flk_pkg.sv
package flk_pkg;
  localparam int CFG_W     = 8;
  localparam int BIT_EN    = 0;
  localparam int BIT_FMODE = 1;
  localparam int BIT_RATIO = 2;
  localparam int BIT_TSEL  = 3;

  typedef struct packed {
    logic fmode;
    logic ratio;
    logic tsel_low;
  } flk_ctrl_t;
endpackage

// File: rtl/flk_ctrl_reg.sv
module flk_ctrl_reg
  import flk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output flk_ctrl_t        ctrl_eff
);
  logic [CFG_W-1:0] ctrl_q;
  logic             master_en;

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data;
  end

  assign rd_data   = ctrl_q;
  assign master_en = ctrl_q[BIT_EN];

  // gated view: every mode bit is masked by the master enable
  always_comb begin
    ctrl_eff.fmode    = master_en & ctrl_q[BIT_FMODE];
    ctrl_eff.ratio    = master_en & ctrl_q[BIT_RATIO];
    ctrl_eff.tsel_low = master_en & ctrl_q[BIT_TSEL];
  end
endmodule

// File: rtl/flk_blend.sv
module flk_blend #(
  parameter int DW    = 8,
  parameter int HI_TH = 32,
  parameter int LO_TH = 8
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] dly,
  input  logic          ratio,
  input  logic          tsel_low,
  output logic          exceed,
  output logic [DW-1:0] result
);
  localparam int IW = DW + 2;

  function automatic logic [DW-1:0] abs_diff(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [DW-1:0] mix_half(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [IW-1:0] s;
    s = IW'(a) + IW'(b) + IW'(1);
    return s[DW:1];
  endfunction

  function automatic logic [DW-1:0] mix_3q(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [IW-1:0] s;
    s = (IW'(a) << 1) + IW'(a) + IW'(b) + IW'(2);
    return s[IW-1:2];
  endfunction

  logic [DW-1:0] diff;
  logic [DW:0]   thr;
  logic [DW-1:0] mixed;

  assign diff   = abs_diff(cur, dly);
  assign thr    = tsel_low ? (DW+1)'(LO_TH) : (DW+1)'(HI_TH);
  assign exceed = {1'b0, diff} > thr;
  assign mixed  = ratio ? mix_3q(cur, dly) : mix_half(cur, dly);
  assign result = exceed ? mixed : cur;
endmodule

// File: rtl/flk_out_stage.sv
module flk_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic          key_i,
  input  logic          fmode,
  input  logic [DW-1:0] cvbs,
  input  logic [DW-1:0] pd,
  input  logic [DW-1:0] filtered,
  output logic          valid_o,
  output logic          key_o,
  output logic [DW-1:0] luma_o
);
  logic [DW-1:0] sel;

  always_comb begin
    if (key_i)      sel = cvbs;
    else if (fmode) sel = filtered;
    else            sel = pd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      key_o   <= 1'b0;
      luma_o  <= '0;
    end else begin
      valid_o <= valid_i;
      key_o   <= key_i;
      luma_o  <= sel;
    end
  end
endmodule

// File: rtl/luma_flicker_filter.sv
module luma_flicker_filter
  import flk_pkg::*;
#(
  parameter int DW    = 8,
  parameter int HI_TH = 32,
  parameter int LO_TH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             in_valid,
  input  logic             in_key,
  input  logic [DW-1:0]    in_cvbs,
  input  logic [DW-1:0]    in_pd,
  output logic             out_valid,
  output logic             out_key,
  output logic [DW-1:0]    out_luma
);
  flk_ctrl_t     ctrl;
  logic          exceed;
  logic [DW-1:0] filtered;
  logic          filt_mode_eff;
  logic          blend_fire;

  flk_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .rd_data  (cfg_rdata),
    .ctrl_eff (ctrl)
  );

  flk_blend #(.DW(DW), .HI_TH(HI_TH), .LO_TH(LO_TH)) u_blend (
    .cur      (in_pd),
    .dly      (in_cvbs),
    .ratio    (ctrl.ratio),
    .tsel_low (ctrl.tsel_low),
    .exceed   (exceed),
    .result   (filtered)
  );

  // named events for the checker
  assign filt_mode_eff = ctrl.fmode;
  assign blend_fire    = ctrl.fmode & ~in_key & exceed;

  flk_out_stage #(.DW(DW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (in_valid),
    .key_i    (in_key),
    .fmode    (ctrl.fmode),
    .cvbs     (in_cvbs),
    .pd       (in_pd),
    .filtered (filtered),
    .valid_o  (out_valid),
    .key_o    (out_key),
    .luma_o   (out_luma)
  );
endmodule

// File: rtl/flk_checker.sv
module flk_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [7:0]    cfg_rdata,
  input logic          in_valid,
  input logic          in_key,
  input logic [DW-1:0] in_cvbs,
  input logic [DW-1:0] in_pd,
  input logic          out_valid,
  input logic          out_key,
  input logic [DW-1:0] out_luma,
  input logic          filt_mode_eff,
  input logic          blend_fire
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_key && out_luma == '0 && cfg_rdata == '0));

  a_r2_strobe_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid) && out_key == $past(in_key)));

  a_r3_keyer_path: assert property (@(posedge clk) disable iff (rst)
    !filt_mode_eff |=> out_luma == ($past(in_key) ? $past(in_cvbs) : $past(in_pd)));

  a_r4_key_over: assert property (@(posedge clk) disable iff (rst)
    in_key |=> out_luma == $past(in_cvbs));

  a_r5_quiet_pass: assert property (@(posedge clk) disable iff (rst)
    (filt_mode_eff && !in_key && !blend_fire) |=> out_luma == $past(in_pd));

  a_r11_bounded: assert property (@(posedge clk) disable iff (rst)
    blend_fire |=> (out_luma >= (($past(in_pd) < $past(in_cvbs)) ? $past(in_pd) : $past(in_cvbs)) &&
                    out_luma <= (($past(in_pd) > $past(in_cvbs)) ? $past(in_pd) : $past(in_cvbs))));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_rdata));
endmodule

bind luma_flicker_filter flk_checker #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_we        (cfg_we),
  .cfg_rdata     (cfg_rdata),
  .in_valid      (in_valid),
  .in_key        (in_key),
  .in_cvbs       (in_cvbs),
  .in_pd         (in_pd),
  .out_valid     (out_valid),
  .out_key       (out_key),
  .out_luma      (out_luma),
  .filt_mode_eff (filt_mode_eff),
  .blend_fire    (blend_fire)
);

// File: tb/tb_luma_flicker_filter.sv
module tb_luma_flicker_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       in_valid = 1'b0;
  logic       in_key = 1'b0;
  logic [7:0] in_cvbs = '0;
  logic [7:0] in_pd = '0;
  logic       out_valid;
  logic       out_key;
  logic [7:0] out_luma;

  int tests = 0;
  int fails = 0;
  logic [7:0] cfg_shadow = '0;

  always #4 clk = ~clk;

  luma_flicker_filter dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_key(in_key), .in_cvbs(in_cvbs), .in_pd(in_pd),
    .out_valid(out_valid), .out_key(out_key), .out_luma(out_luma)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic int ref_luma(input logic [7:0] c, input int key, input int cv, input int pd);
    int d, th;
    if (key != 0) return cv;
    if (!(c[0] && c[1])) return pd;
    d  = (pd > cv) ? pd - cv : cv - pd;
    th = c[3] ? 8 : 32;
    if (d <= th) return pd;
    if (c[2]) return (pd * 3 + cv + 2) / 4;
    return (pd + cv + 1) / 2;
  endfunction

  function automatic string req_of(input logic [7:0] c, input int key, input int cv, input int pd);
    int d, th;
    if (!c[0]) return "R9";
    if (!c[1]) return "R3";
    if (key != 0) return "R4";
    d  = (pd > cv) ? pd - cv : cv - pd;
    th = c[3] ? 8 : 32;
    if (d <= th) return "R5/R8";
    return c[2] ? "R7/R8" : "R6/R8";
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_shadow = v;
    chk("R10 readback", int'(cfg_rdata), int'(v));
  endtask

  task automatic push(input logic v, input logic k, input logic [7:0] cv, input logic [7:0] pd);
    int e;
    string r;
    in_valid = v; in_key = k; in_cvbs = cv; in_pd = pd;
    e = ref_luma(cfg_shadow, int'(k), int'(cv), int'(pd));
    r = req_of(cfg_shadow, int'(k), int'(cv), int'(pd));
    @(negedge clk);
    chk(r, int'(out_luma), e);
    chk("R2 valid", int'(out_valid), int'(v));
    chk("R2 key", int'(out_key), int'(k));
    if (r == "R6/R8" || r == "R7/R8")
      chk("R11 bound", int'((out_luma >= ((pd < cv) ? pd : cv)) && (out_luma <= ((pd > cv) ? pd : cv))), 1);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 key", int'(out_key), 0);
    chk("R1 luma", int'(out_luma), 0);
    chk("R1 rdata", int'(cfg_rdata), 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 plain keyer at reset config
    push(1, 1, 8'd200, 8'd10);
    push(1, 0, 8'd200, 8'd10);

    // R8 high threshold boundary, R6 half blend
    write_cfg(8'h03);
    push(1, 0, 8'd100, 8'd132);   // diff 32: pass (R5/R8)
    push(1, 0, 8'd100, 8'd133);   // diff 33: blend -> 117 (R6)
    push(1, 0, 8'd133, 8'd100);   // reversed direction
    push(1, 0, 8'd0, 8'd255);     // extremes -> 128
    push(1, 1, 8'd77, 8'd5);      // R4 key over

    // R8 low threshold, R7 three-quarter blend
    write_cfg(8'h0F);
    push(1, 0, 8'd50, 8'd58);     // diff 8: pass
    push(1, 0, 8'd50, 8'd59);     // diff 9: blend -> 57
    push(1, 0, 8'd0, 8'd255);     // 191
    push(1, 0, 8'd255, 8'd0);     // 64

    // R9 enable clear: other bits ignored
    write_cfg(8'hFE);
    push(1, 0, 8'd0, 8'd255);
    push(1, 1, 8'd0, 8'd255);
    write_cfg(8'hA5);             // R10 upper bits kept; filter mode off -> R3
    push(0, 0, 8'd9, 8'd90);

    // random mix
    for (int g = 0; g < 40; g++) begin
      logic [7:0] c;
      c = 8'($urandom());
      if ($urandom_range(0, 2) != 0) c[1:0] = 2'b11;
      write_cfg(c);
      for (int i = 0; i < 40; i++) begin
        logic [7:0] cv, pd;
        cv = 8'($urandom());
        if ($urandom_range(0, 1) == 0) pd = 8'($urandom());
        else pd = 8'(int'(cv) + $urandom_range(0, 40) - 20);
        push(1'($urandom()), 1'($urandom_range(0, 3) == 0), cv, pd);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule